// File: doc/BRIEF.md
# Resonance-Seeking Oscillator Code Calibrator

This block finds the digital oscillator code that puts an on-off-keyed carrier at the resonance of a shared interconnect network. The resonance is not known in advance. While calibration runs, the node sends a steady test carrier and its own receiver picks it up. An analog-to-digital converter digitises the receiver's envelope peak detector. The controller sets a code and waits a programmable settling time so the envelope can settle. It then asks for one converter sample and uses the result to climb toward the code with the largest amplitude.

The climb is a halving-step hill climb over a configured code window. It starts at the middle of the window with a configured initial step. At each position it tries one step up, then one step down. It moves whenever a probe gives a strictly larger amplitude. When neither probe helps, it halves the step. It stops once a step of one gives no improvement. At that point the best code is driven on the oscillator code output and on the locked-code output, the done flag rises and the test carrier turns off. A fresh start strobe runs a new calibration.

Top module: `dco_res_cal`

## Requirements
- R1: After reset, `cal_done`, `tx_en` and `adc_req` are 0, and both `dco_code` and `cal_code` are 0.
- R2: A start strobe taken while idle or done raises `tx_en`. The first measured code is the window midpoint, min + floor((max - min) / 2).
- R3: After every change of `dco_code`, `adc_req` stays low for at least `cfg_settle` + 1 clock cycles.
- R4: Once `adc_req` is high, it stays high and `dco_code` stays unchanged until a cycle in which `adc_ack` is high. The sample is taken from `adc_data` in that cycle.
- R5: Every code presented for a measurement lies within [`cfg_code_min`, `cfg_code_max`]. Probes are clamped to that window, and a probe that clamps back onto the current code is not measured.
- R6: When the amplitude falls strictly on both sides of a single peak, the locked code is the peak code clamped into the window.
- R7: On completion `cal_done` is 1 and `tx_en` is 0, and `dco_code` and `cal_code` both equal the locked code.
- R8: An initial step of 0 is treated as a step of 1.
- R9: A move needs a strictly larger amplitude. With a flat amplitude profile the locked code is the window midpoint.
- R10: A start strobe while done begins a new run: in the next cycle `cal_done` is 0 and `tx_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cal_start | input | 1 | One-cycle strobe that begins a calibration |
| cfg_code_min | input | CODE_W | Lowest allowed oscillator code |
| cfg_code_max | input | CODE_W | Highest allowed oscillator code (must be no less than the minimum) |
| cfg_step_init | input | CODE_W | Initial search step |
| cfg_settle | input | SETTLE_W | Extra settling cycles after each code change |
| adc_req | output | 1 | Sample request to the converter |
| adc_ack | input | 1 | Converter sample valid, completes the request |
| adc_data | input | AMP_W | Digitised envelope amplitude |
| dco_code | output | CODE_W | Code driving the oscillator |
| tx_en | output | 1 | Enables the test carrier |
| cal_done | output | 1 | Calibration finished, code locked |
| cal_code | output | CODE_W | Locked code |

## Verification
Two things can happen in the same cycle: a converter sample is accepted, and that sample decides a move and whether the next probe is needed. The responder varies the acknowledge delay from zero to three cycles, so an acknowledge can arrive in the very cycle the request first rises. It also checks at every acknowledge that the code is in range and the settling gap was respected. Another overlap sits at the window edges, where a clamped probe is skipped and the step shrinks with no measurement at all. Narrow windows and peaks outside the window provoke this, and the locked code is judged against the clamped peak.

// File: rtl/dco_res_cal_pkg.sv
package dco_res_cal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PLAN   = 3'd1,
    ST_SETTLE = 3'd2,
    ST_SAMPLE = 3'd3,
    ST_LOCKED = 3'd4
  } cal_state_e;

  // which probe the next measurement belongs to
  typedef enum logic [1:0] {
    PH_CENTRE = 2'd0,
    PH_UP     = 2'd1,
    PH_DOWN   = 2'd2,
    PH_SHRINK = 2'd3
  } probe_phase_e;

endpackage

// File: rtl/dco_res_cal_rst_sync.sv
module dco_res_cal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/dco_res_cal_settle.sv
module dco_res_cal_settle #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [SETTLE_W-1:0] limit,
  output logic                expired
);

  logic [SETTLE_W-1:0] cnt_q;
  logic [SETTLE_W-1:0] cnt_d;
  logic                cnt_en;

  assign expired = run && (cnt_q == limit);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (!expired) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit)) else $error("settle counter passed its limit"); // R3

endmodule

// File: rtl/dco_res_cal_probe.sv
module dco_res_cal_probe #(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] centre,
  input  logic [CODE_W-1:0] step,
  input  logic [CODE_W-1:0] code_min,
  input  logic [CODE_W-1:0] code_max,
  output logic [CODE_W-1:0] probe_up,
  output logic [CODE_W-1:0] probe_dn
);

  localparam int EXT_W = CODE_W + 1;

  logic [EXT_W-1:0] up_sum;
  logic [EXT_W-1:0] dn_floor;

  always_comb begin
    up_sum   = {1'b0, centre} + {1'b0, step};
    dn_floor = {1'b0, code_min} + {1'b0, step};
    if (up_sum > {1'b0, code_max}) begin
      probe_up = code_max;
    end else begin
      probe_up = up_sum[CODE_W-1:0];
    end
    if ({1'b0, centre} < dn_floor) begin
      probe_dn = code_min;
    end else begin
      probe_dn = centre - step;
    end
  end

endmodule

// File: rtl/dco_res_cal_fsm.sv
module dco_res_cal_fsm
  import dco_res_cal_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int AMP_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_start,
  input  logic [CODE_W-1:0] cfg_code_min,
  input  logic [CODE_W-1:0] cfg_code_max,
  input  logic [CODE_W-1:0] cfg_step_init,
  input  logic              settle_expired,
  input  logic              adc_ack,
  input  logic [AMP_W-1:0]  adc_data,
  input  logic [CODE_W-1:0] probe_up,
  input  logic [CODE_W-1:0] probe_dn,
  output logic [CODE_W-1:0] centre,
  output logic [CODE_W-1:0] step,
  output logic              settle_run,
  output logic              adc_req,
  output logic [CODE_W-1:0] dco_code,
  output logic              tx_en,
  output logic              cal_done,
  output logic [CODE_W-1:0] cal_code
);

  cal_state_e   state_q, state_d;
  probe_phase_e phase_q, phase_d;
  logic [CODE_W-1:0] centre_q, centre_d;
  logic [CODE_W-1:0] step_q, step_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [CODE_W-1:0] lock_q, lock_d;
  logic [AMP_W-1:0]  best_q, best_d;
  logic              tx_q, tx_d;
  logic              done_q, done_d;
  logic              reg_en;

  logic [CODE_W-1:0] span;
  logic [CODE_W-1:0] mid_code;
  logic [CODE_W-1:0] first_step;
  logic              better;

  assign span       = cfg_code_max - cfg_code_min;
  assign mid_code   = cfg_code_min + (span >> 1);
  assign first_step = (cfg_step_init == '0) ? {{(CODE_W-1){1'b0}}, 1'b1} : cfg_step_init;
  assign better     = (adc_data > best_q);

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    centre_d = centre_q;
    step_d   = step_q;
    code_d   = code_q;
    lock_d   = lock_q;
    best_d   = best_q;
    tx_d     = tx_q;
    done_d   = done_q;
    unique case (state_q)
      ST_IDLE, ST_LOCKED: begin
        if (cal_start) begin
          centre_d = mid_code;
          code_d   = mid_code;
          step_d   = first_step;
          phase_d  = PH_CENTRE;
          tx_d     = 1'b1;
          done_d   = 1'b0;
          state_d  = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (settle_expired) begin
          state_d = ST_SAMPLE;
        end
      end
      ST_SAMPLE: begin
        if (adc_ack) begin
          state_d = ST_PLAN;
          unique case (phase_q)
            PH_CENTRE: begin
              best_d  = adc_data;
              phase_d = PH_UP;
            end
            PH_UP: begin
              if (better) begin
                best_d   = adc_data;
                centre_d = code_q;
              end else begin
                phase_d = PH_DOWN;
              end
            end
            default: begin
              if (better) begin
                best_d   = adc_data;
                centre_d = code_q;
                phase_d  = PH_UP;
              end else begin
                phase_d = PH_SHRINK;
              end
            end
          endcase
        end
      end
      ST_PLAN: begin
        unique case (phase_q)
          PH_UP: begin
            if (probe_up != centre_q) begin
              code_d  = probe_up;
              state_d = ST_SETTLE;
            end else begin
              phase_d = PH_DOWN;
            end
          end
          PH_DOWN: begin
            if (probe_dn != centre_q) begin
              code_d  = probe_dn;
              state_d = ST_SETTLE;
            end else begin
              phase_d = PH_SHRINK;
            end
          end
          default: begin
            if (step_q <= {{(CODE_W-1){1'b0}}, 1'b1}) begin
              code_d  = centre_q;
              lock_d  = centre_q;
              tx_d    = 1'b0;
              done_d  = 1'b1;
              state_d = ST_LOCKED;
            end else begin
              step_d  = step_q >> 1;
              phase_d = PH_UP;
            end
          end
        endcase
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign reg_en = (state_d != state_q) || (phase_d != phase_q) || (state_q == ST_SAMPLE)
                  || (state_q == ST_PLAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_CENTRE;
      centre_q <= '0;
      step_q   <= '0;
      code_q   <= '0;
      lock_q   <= '0;
      best_q   <= '0;
      tx_q     <= 1'b0;
      done_q   <= 1'b0;
    end else if (reg_en) begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      centre_q <= centre_d;
      step_q   <= step_d;
      code_q   <= code_d;
      lock_q   <= lock_d;
      best_q   <= best_d;
      tx_q     <= tx_d;
      done_q   <= done_d;
    end
  end

  assign centre     = centre_q;
  assign step       = step_q;
  assign settle_run = (state_q == ST_SETTLE);
  assign adc_req    = (state_q == ST_SAMPLE);
  assign dco_code   = code_q;
  assign tx_en      = tx_q;
  assign cal_done   = done_q;
  assign cal_code   = lock_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req && !adc_ack) |=> (adc_req && $stable(dco_code))) else $error("request dropped early"); // R4

  AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_run || adc_req) |-> ((dco_code >= cfg_code_min) && (dco_code <= cfg_code_max)))
    else $error("measured code outside window"); // R5

  AST_DONE_TX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (!tx_en && (dco_code == cal_code))) else $error("locked with carrier on"); // R7

  AST_STEP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> (step_q != '0)) else $error("zero search step"); // R8

  AST_BEST_NONDECREASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_PLAN) && ($past(state_q) == ST_SAMPLE) && ($past(phase_q) != PH_CENTRE))
    |-> (best_q >= $past(best_q))) else $error("best amplitude fell"); // R6

endmodule

// File: rtl/dco_res_cal.sv
module dco_res_cal #(
  parameter int CODE_W   = 8,
  parameter int AMP_W    = 12,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cal_start,
  input  logic [CODE_W-1:0]   cfg_code_min,
  input  logic [CODE_W-1:0]   cfg_code_max,
  input  logic [CODE_W-1:0]   cfg_step_init,
  input  logic [SETTLE_W-1:0] cfg_settle,
  output logic                adc_req,
  input  logic                adc_ack,
  input  logic [AMP_W-1:0]    adc_data,
  output logic [CODE_W-1:0]   dco_code,
  output logic                tx_en,
  output logic                cal_done,
  output logic [CODE_W-1:0]   cal_code
);

  logic              rst_n_s;
  logic              settle_run;
  logic              settle_expired;
  logic [CODE_W-1:0] centre;
  logic [CODE_W-1:0] step;
  logic [CODE_W-1:0] probe_up;
  logic [CODE_W-1:0] probe_dn;

  dco_res_cal_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  dco_res_cal_settle #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .run     (settle_run),
    .limit   (cfg_settle),
    .expired (settle_expired)
  );

  dco_res_cal_probe #(.CODE_W(CODE_W)) u_probe (
    .centre   (centre),
    .step     (step),
    .code_min (cfg_code_min),
    .code_max (cfg_code_max),
    .probe_up (probe_up),
    .probe_dn (probe_dn)
  );

  dco_res_cal_fsm #(.CODE_W(CODE_W), .AMP_W(AMP_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n_s),
    .cal_start      (cal_start),
    .cfg_code_min   (cfg_code_min),
    .cfg_code_max   (cfg_code_max),
    .cfg_step_init  (cfg_step_init),
    .settle_expired (settle_expired),
    .adc_ack        (adc_ack),
    .adc_data       (adc_data),
    .probe_up       (probe_up),
    .probe_dn       (probe_dn),
    .centre         (centre),
    .step           (step),
    .settle_run     (settle_run),
    .adc_req        (adc_req),
    .dco_code       (dco_code),
    .tx_en          (tx_en),
    .cal_done       (cal_done),
    .cal_code       (cal_code)
  );

endmodule

// File: tb/test_dco_res_cal.sv
module test_dco_res_cal;

  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 8;
  localparam int AMP_W      = 12;
  localparam int SETTLE_W   = 8;
  localparam int WATCHDOG   = 150000;

  logic                clk;
  logic                rst_n;
  logic                cal_start;
  logic [CODE_W-1:0]   cfg_code_min;
  logic [CODE_W-1:0]   cfg_code_max;
  logic [CODE_W-1:0]   cfg_step_init;
  logic [SETTLE_W-1:0] cfg_settle;
  logic                adc_req;
  logic                adc_ack;
  logic [AMP_W-1:0]    adc_data;
  logic [CODE_W-1:0]   dco_code;
  logic                tx_en;
  logic                cal_done;
  logic [CODE_W-1:0]   cal_code;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  int peak = 0;
  bit flat = 0;
  bit first_req = 0;
  int since_chg = 0;
  int dly = 0;
  logic [CODE_W-1:0] last_code = '0;

  dco_res_cal #(.CODE_W(CODE_W), .AMP_W(AMP_W), .SETTLE_W(SETTLE_W)) i_dco_res_cal (
    .clk (clk), .rst_n (rst_n), .cal_start (cal_start),
    .cfg_code_min (cfg_code_min), .cfg_code_max (cfg_code_max),
    .cfg_step_init (cfg_step_init), .cfg_settle (cfg_settle),
    .adc_req (adc_req), .adc_ack (adc_ack), .adc_data (adc_data),
    .dco_code (dco_code), .tx_en (tx_en), .cal_done (cal_done), .cal_code (cal_code)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int amp_of(int code);
    int d;
    if (flat) return 1000;
    d = (code > peak) ? code - peak : peak - code;
    return 4000 - 12 * d;
  endfunction

  function automatic int mid_of(int lo, int hi);
    return lo + (hi - lo) / 2;
  endfunction

  function automatic int expect_lock(int lo, int hi);
    if (flat) return mid_of(lo, hi);
    if (peak < lo) return lo;
    if (peak > hi) return hi;
    return peak;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model, acts on falling edges
  always @(negedge clk) begin
    cycles++;
    if (dco_code != last_code) since_chg = 0;
    else since_chg++;
    last_code = dco_code;
    if (adc_ack) begin
      adc_ack = 1'b0;
      check(!adc_req, "R4 req low after ack", int'(adc_req), 0);
    end else if (adc_req) begin
      if (dly == 0) begin
        check(since_chg >= int'(cfg_settle) + 1, "R3 settle gap", since_chg, int'(cfg_settle) + 1);
        check(dco_code >= cfg_code_min && dco_code <= cfg_code_max, "R5 code in window",
              int'(dco_code), int'(cfg_code_min));
        check(tx_en, "R2 carrier on while measuring", int'(tx_en), 1);
        if (first_req) begin
          check(int'(dco_code) == mid_of(int'(cfg_code_min), int'(cfg_code_max)),
                "R2 first code midpoint", int'(dco_code),
                mid_of(int'(cfg_code_min), int'(cfg_code_max)));
          first_req = 0;
        end
        adc_data = AMP_W'(amp_of(int'(dco_code)));
        adc_ack  = 1'b1;
        dly      = int'($urandom % 4);
      end else begin
        dly--;
      end
    end
  end

  task automatic run_cal(int lo, int hi, int st, int settle, int pk, bit is_flat, string tag);
    int n;
    int exp;
    @(negedge clk);
    cfg_code_min  = CODE_W'(lo);
    cfg_code_max  = CODE_W'(hi);
    cfg_step_init = CODE_W'(st);
    cfg_settle    = SETTLE_W'(settle);
    peak = pk;
    flat = is_flat;
    first_req = 1;
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    check(!cal_done && tx_en, "R10 restart clears done", int'(cal_done), 0);
    n = 0;
    while (!cal_done && n < 20000 && cycles < WATCHDOG) begin
      @(negedge clk);
      n++;
    end
    exp = expect_lock(lo, hi);
    check(cal_done, {tag, " R7 done raised"}, int'(cal_done), 1);
    check(!tx_en, {tag, " R7 carrier off"}, int'(tx_en), 0);
    check(int'(cal_code) == exp, {tag, " R6 locked code"}, int'(cal_code), exp);
    check(int'(dco_code) == exp, {tag, " R7 output code"}, int'(dco_code), exp);
  endtask

  initial begin
    int lo, hi;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; cal_start = 1'b0; adc_ack = 1'b0; adc_data = '0;
    cfg_code_min = '0; cfg_code_max = '0; cfg_step_init = '0; cfg_settle = '0;
    repeat (3) @(negedge clk);
    check(!cal_done && !tx_en && !adc_req, "R1 reset flags", int'(cal_done), 0);
    check(dco_code == '0 && cal_code == '0, "R1 reset codes", int'(dco_code), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!adc_req && !tx_en, "R1 idle after release", int'(adc_req), 0);

    run_cal(20, 220, 32, 3, 137, 0, "dir-mid");
    run_cal(20, 220, 16, 2, 250, 0, "dir-above");       // R6 peak beyond max
    run_cal(60, 200, 16, 2, 5, 0, "dir-below");         // R6 peak below min
    run_cal(30, 180, 0, 1, 77, 0, "R8 step0");
    run_cal(10, 200, 8, 2, 0, 1, "R9 flat");
    run_cal(90, 90, 4, 0, 10, 0, "R5 single");
    run_cal(0, 255, 64, 0, 255, 0, "full-top");
    run_cal(0, 255, 64, 12, 1, 0, "R3 long settle");

    for (int i = 0; i < 12; i++) begin
      lo = int'($urandom % 100);
      hi = lo + int'($urandom % (256 - lo));
      run_cal(lo, hi, int'($urandom % 40), int'($urandom % 6), int'($urandom % 256), 0, "rand");
    end

    if (cycles >= WATCHDOG) check(0, "watchdog", cycles, WATCHDOG);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * (WATCHDOG + 10000));
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, WATCHDOG);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule